// File: doc/BRIEF.md
# Ping-Pong Sample Capture Buffer

This block records a continuous stream of 16-bit converter samples into banked on-chip storage split into two equal halves. The lower half of the banks is the ping half and the upper half is the pong half. Each valid sample goes to the next word in a single running write position. That position runs through every word of a bank, then moves to the next bank. After the last word of the last bank it returns to word 0 of bank 0.

When the last word of a half has been written, the block flips a half-select level and raises a one-cycle interrupt pulse. The host then copies out the finished half through a read port, while new samples keep filling the other half. The host addresses a word with a bank index and a word address inside that bank.

Read data is driven combinationally from the selected word, with no output register. A word is therefore valid in the same cycle its address is presented. The host confirms that it has taken a half with an acknowledge pulse. If a second half finishes before that acknowledge arrives, a sticky overrun flag is raised. Reading from the half that is still being filled returns the stored data but raises a sticky collision flag. The default build uses 16 banks of 128 words. Setting `BANK_AW` to 10 gives banks of 1024 words.

Top module: `pingpong_capture`

## Requirements
- R1: Each cycle with `sampleValid` high stores `sampleData` at the current write position, and the position then advances by one word.
- R2: The write position starts at bank 0 word 0. It steps through words 0 to 2^BANK_AW-1 of a bank, then moves to word 0 of the next bank. After the last word of bank NUM_BANKS-1 it wraps to bank 0 word 0.
- R3: `rdData` equals the stored word at `rdBank`/`rdAddr` in the same cycle those inputs are applied, with no clock edge between.
- R4: `pingPong` is 0 while the write position is in banks 0 to NUM_BANKS/2-1 and 1 while it is in the upper banks. It changes only on the edge that writes the last word of a half.
- R5: `irq` is high for exactly one cycle, the cycle right after the edge that writes the last word of either half.
- R6: `overrun` is set when a half completes while the previous completion has not been acknowledged by a `hostAck` pulse. A `hostAck` in the same cycle as the completing write counts as acknowledging the previous half.
- R7: `overrun` and `rdCollide` stay set until a cycle with `flagClr` high clears them. A new set event in the clearing cycle takes priority.
- R8: A cycle with `rdEn` high whose `rdBank` lies in the half being written sets `rdCollide` after that edge, and the read data remains correct. Reads of the other half leave `rdCollide` unchanged.
- R9: After reset the write position is bank 0 word 0, and `pingPong`, `irq`, `overrun` and `rdCollide` are 0. Storage contents are undefined.
- R10: A cycle with `sampleValid` low writes nothing and does not move the write position, whatever value `sampleData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | SAMPLE_W | Sample value |
| rdEn | input | 1 | Host read qualifier, used for collision detection |
| rdBank | input | $clog2(NUM_BANKS) | Bank index of the host read |
| rdAddr | input | BANK_AW | Word address inside the bank |
| hostAck | input | 1 | Acknowledge pulse for the completed half |
| flagClr | input | 1 | Clears the sticky flags |
| rdData | output | SAMPLE_W | Combinational read data |
| pingPong | output | 1 | Half being written (0 ping, 1 pong) |
| irq | output | 1 | One-cycle pulse when a half completes |
| overrun | output | 1 | Sticky overrun flag |
| rdCollide | output | 1 | Sticky flag for a read of the half being filled |

## Verification
The bench uses a reduced build of four banks of eight words, so two full laps of the storage are short. It checks every word against an arithmetic sample sequence. Writes are issued both back to back and with idle gaps in which junk appears on the data input. This separates a correct pointer from one that advances or writes on idle cycles, and a complete readback catches wrong bank ordering or a broken wrap.

The acknowledge is tested in three ways: given before the next completion, withheld, and given in the same cycle as the completion. These separate a correct overrun rule from one that ignores the acknowledge or gets the same-cycle case wrong. Reads are sampled before any clock edge, which exposes a read path that has a register added. Reads of each half in turn show that the collision flag responds only to the half being filled.

// File: rtl/pingpong_capture_pkg.sv
package pingpong_capture_pkg;
  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic wrEn;     // store the sample at the write position
    logic halfDone; // this write is the last word of a half
  } ctrlStrobes_t;
endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pingpong_capture_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int BANK_AW   = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int PTR_W    = BANK_W + BANK_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              rdEn,
  input  logic [BANK_W-1:0] rdBank,
  input  logic              hostAck,
  input  logic              flagClr,
  output ctrlStrobes_t      strb,
  output logic [PTR_W-1:0]  wrPtr,
  output logic              pingPong,
  output logic              irq,
  output logic              overrun,
  output logic              rdCollide
);
  logic pending;
  logic lastOfHalf;
  logic collideNow;

  // The low pointer bits are all ones on the final word of a half.
  assign lastOfHalf    = &wrPtr[PTR_W-2:0];
  assign strb.wrEn     = sampleValid;
  assign strb.halfDone = sampleValid && lastOfHalf;
  assign pingPong      = wrPtr[PTR_W-1];
  assign collideNow    = rdEn && (rdBank[BANK_W-1] == wrPtr[PTR_W-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      irq       <= 1'b0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
      rdCollide <= 1'b0;
    end else begin
      irq <= strb.halfDone;
      if (sampleValid) wrPtr <= wrPtr + 1'b1;
      if (strb.halfDone) pending <= 1'b1;
      else if (hostAck) pending <= 1'b0;
      if (strb.halfDone && pending && !hostAck) overrun <= 1'b1;
      else if (flagClr) overrun <= 1'b0;
      if (collideNow) rdCollide <= 1'b1;
      else if (flagClr) rdCollide <= 1'b0;
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R5
  AST_PP_FLIP_ON_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pingPong != $past(pingPong))); // R4
  AST_PP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> $stable(pingPong)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !flagClr) |=> overrun); // R7
  AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (!rstN)
    collideNow |=> rdCollide); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !irq); // R10
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pingpong_capture_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_BANKS = 16,
  parameter int BANK_AW   = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int DEPTH    = 1 << BANK_AW,
  localparam int PTR_W    = BANK_W + BANK_AW
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [PTR_W-1:0]    wrPtr,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [BANK_W-1:0]   rdBank,
  input  logic [BANK_AW-1:0]  rdAddr,
  output logic [SAMPLE_W-1:0] rdData
);
  logic [BANK_W-1:0]   wrBank;
  logic [BANK_AW-1:0]  wrAddr;
  logic [SAMPLE_W-1:0] bankRd [NUM_BANKS];

  assign wrBank = wrPtr[PTR_W-1 -: BANK_W];
  assign wrAddr = wrPtr[BANK_AW-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [SAMPLE_W-1:0] bankMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrEn && (wrBank == BANK_W'(b))) bankMem[wrAddr] <= sampleData;
    end
    assign bankRd[b] = bankMem[rdAddr];
  end

  // Plain multiplexer on the read side: data is valid in the address cycle.
  assign rdData = bankRd[rdBank];

  AST_HALF_END_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    strb.halfDone |-> (strb.wrEn && (&wrAddr) && (&wrBank[BANK_W-2:0] || BANK_W == 1))); // R2
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
  import pingpong_capture_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_BANKS = 16,
  parameter int BANK_AW   = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int PTR_W    = BANK_W + BANK_AW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                rdEn,
  input  logic [BANK_W-1:0]   rdBank,
  input  logic [BANK_AW-1:0]  rdAddr,
  input  logic                hostAck,
  input  logic                flagClr,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                pingPong,
  output logic                irq,
  output logic                overrun,
  output logic                rdCollide
);
  ctrlStrobes_t     strb;
  logic [PTR_W-1:0] wrPtr;

  pp_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdEn(rdEn),
    .rdBank(rdBank), .hostAck(hostAck), .flagClr(flagClr), .strb(strb),
    .wrPtr(wrPtr), .pingPong(pingPong), .irq(irq), .overrun(overrun),
    .rdCollide(rdCollide)
  );

  pp_datapath #(.SAMPLE_W(SAMPLE_W), .NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .sampleData(sampleData),
    .rdBank(rdBank), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/pingpong_capture_bench.sv
module pingpong_capture_bench;
  localparam int NB    = 4;
  localparam int AW    = 3;
  localparam int WORDS = NB << AW;
  localparam int HALF  = WORDS / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic rdEn = 1'b0;
  logic [1:0] rdBank = '0;
  logic [AW-1:0] rdAddr = '0;
  logic hostAck = 1'b0;
  logic flagClr = 1'b0;
  logic [15:0] rdData;
  logic pingPong, irq, overrun, rdCollide;

  int errors = 0;
  int checks = 0;
  int wIdx = 0;
  logic [15:0] expMem [WORDS];

  always #2 clk = ~clk; // 250 MHz

  pingpong_capture #(.SAMPLE_W(16), .NUM_BANKS(NB), .BANK_AW(AW)) u_pingpong_capture (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .rdEn(rdEn), .rdBank(rdBank), .rdAddr(rdAddr), .hostAck(hostAck),
    .flagClr(flagClr), .rdData(rdData), .pingPong(pingPong), .irq(irq),
    .overrun(overrun), .rdCollide(rdCollide)
  );

  function automatic logic [15:0] smp(int i);
    return 16'((i * 977 + 16'h1357) & 16'hFFFF);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // One write; the outputs are checked after the edge that performs it.
  task automatic writeOne(bit ack);
    int pos = wIdx % WORDS;
    bit last = ((wIdx % HALF) == HALF - 1);
    sampleValid = 1'b1; sampleData = smp(wIdx); hostAck = ack;
    tick();
    sampleValid = 1'b0; hostAck = 1'b0; sampleData = 16'hDEAD;
    expMem[pos] = smp(wIdx);
    wIdx++;
    check(irq == last, "R5 irq after write", int'(irq), int'(last));
    check(pingPong == (((wIdx / HALF) % 2) == 1), "R4 pingPong",
          int'(pingPong), (wIdx / HALF) % 2);
  endtask

  task automatic readChk(int bank, int addr, string req);
    rdEn = 1'b1; rdBank = 2'(bank); rdAddr = AW'(addr);
    #1;
    check(rdData == expMem[bank * (1 << AW) + addr], req,
          int'(rdData), int'(expMem[bank * (1 << AW) + addr]));
    tick();
    rdEn = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    // R9: reset state
    check(pingPong == 0, "R9 pingPong", int'(pingPong), 0);
    check(irq == 0, "R9 irq", int'(irq), 0);
    check(overrun == 0, "R9 overrun", int'(overrun), 0);
    check(rdCollide == 0, "R9 rdCollide", int'(rdCollide), 0);

    // Ping half, with idle gaps carrying junk data (R10, R1)
    for (int i = 0; i < HALF; i++) begin
      writeOne(1'b0);
      if (i % 3 == 1) begin
        sampleData = 16'hBEEF; tick(); tick();
        check(irq == 0, "R10 idle no irq", int'(irq), 0);
      end
    end
    tick();
    check(irq == 0, "R5 irq one cycle", int'(irq), 0);
    check(overrun == 0, "R6 first half no overrun", int'(overrun), 0);

    hostAck = 1'b1; tick(); hostAck = 1'b0;

    // Combinational readback of the ping half (R3, R1, R2, R10)
    for (int b = 0; b < NB / 2; b++)
      for (int a = 0; a < (1 << AW); a++)
        readChk(b, a, "R3 R1 R10 ping readback");
    check(rdCollide == 0, "R8 idle-half read no collide", int'(rdCollide), 0);

    // Read the half being filled (R8)
    rdEn = 1'b1; rdBank = 2'(NB / 2); rdAddr = '0; tick(); rdEn = 1'b0;
    check(rdCollide == 1, "R8 collide set", int'(rdCollide), 1);
    tick();
    check(rdCollide == 1, "R7 collide sticky", int'(rdCollide), 1);
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    check(rdCollide == 0, "R7 collide clear", int'(rdCollide), 0);

    // Pong half, acknowledged earlier -> no overrun
    for (int i = 0; i < HALF; i++) writeOne(1'b0);
    check(overrun == 0, "R6 acked no overrun", int'(overrun), 0);
    // Wrap into ping without acknowledge -> overrun
    for (int i = 0; i < HALF; i++) writeOne(1'b0);
    check(overrun == 1, "R6 overrun set", int'(overrun), 1);
    readChk(0, 0, "R2 wrap to bank0 word0");
    repeat (5) tick();
    check(overrun == 1, "R7 overrun sticky", int'(overrun), 1);
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    check(overrun == 0, "R7 overrun clear", int'(overrun), 0);

    // Completion with acknowledge in the same cycle -> no overrun (R6)
    for (int i = 0; i < HALF - 1; i++) writeOne(1'b0);
    writeOne(1'b1);
    check(overrun == 0, "R6 same-cycle ack", int'(overrun), 0);

    // Full readback of both halves (R1, R2)
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < (1 << AW); a++)
        readChk(b, a, "R1 R2 full readback");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule